// File: doc/BRIEF.md
# Single-Channel Command Cache Queue

This block is the waiting area between a command pusher and a command puller that feeds a graphics engine. Every queued command carries a 3-bit subchannel, an 11-bit method and a 32-bit data word. The block does not store a channel number with each entry. It holds one current-channel register for the whole queue, so every command in the queue belongs to that channel.

A push whose channel tag matches the current channel is queued if push access is enabled and there is room. A push with a different tag may take over the queue only when the queue is completely empty and channel switching is enabled. In that case the current-channel register loads the new tag on the same edge that accepts the push. Every push that is not queued is reported as a one-cycle runout pulse and is never stalled.

The put and get indices are Gray-coded counters with one extra wrap bit, and both are visible at the ports. The puller side has one registered output stage. It hands out an entry only while pull is enabled, and an entry leaves only on a valid/ready handshake. A global enable input, while low, clears the three control bits.

Top module: `cmd_cache_fifo`

## Requirements
- R1: Entries leave in the order they were accepted, with subchannel (3 bits), method (11 bits) and data (32 bits) unchanged.
- R2: With pull stopped, the queue holds exactly 2**ADDR_W entries (32 by default) and then raises `full`. A further push is answered with `runout` and is not stored.
- R3: A push whose channel differs from `cur_chan` while the queue is not empty is refused with `runout`, and `cur_chan` keeps its value.
- R4: A push whose channel differs from `cur_chan`, made while the queue is empty and switching is enabled, is accepted. `cur_chan` shows the new tag in the same cycle that `push_ok` pulses, and `cur_chan` changes at no other time.
- R5: With switching disabled, a push for a different channel is refused even when the queue is empty. A push for the current channel is still accepted.
- R6: A push made while push access is disabled is refused with `runout`, and nothing enters the queue.
- R7: For every push attempt, exactly one of `push_ok` and `runout` pulses for one cycle, in the cycle after the edge that sampled the push. The two never pulse together.
- R8: `put_gray` and `get_gray` equal the Gray code n^(n>>1) of the number of entries written and read, modulo 2**(ADDR_W+1). Each changes by exactly one bit per step. `empty` and `full` are never high together.
- R9: `pull_valid` is high only while pull is enabled. An entry is removed only in a cycle where `pull_valid` and `pull_ready` are both high. While `pull_ready` is low, the presented entry is held stable.
- R10: While `glb_en` is low, push access, pull enable and switch enable are forced to 0, and control writes are ignored. The bits stay 0 after `glb_en` returns high, until they are written again.
- R11: A control write (`cfg_wr` high) loads `cfg_wdata`: bit 0 is push access, bit 1 is pull enable, bit 2 is switch enable.
- R12: After reset the block is `empty`, not `full`, has no `pull_valid`, `push_ok` or `runout`, and both Gray indices and `cur_chan` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global enable; low clears the control bits |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control bits: [0] push, [1] pull, [2] switch |
| push_valid | input | 1 | Push attempt this cycle |
| push_chan | input | CHAN_W | Channel tag of the push |
| push_subch | input | 3 | Subchannel of the command |
| push_method | input | 11 | Method of the command |
| push_data | input | 32 | Data of the command |
| push_ok | output | 1 | Pulse: previous push was queued |
| runout | output | 1 | Pulse: previous push was refused |
| cur_chan | output | CHAN_W | Channel that owns the queue |
| pull_valid | output | 1 | Entry presented to the puller |
| pull_ready | input | 1 | Puller takes the entry |
| pull_subch | output | 3 | Subchannel of the presented entry |
| pull_method | output | 11 | Method of the presented entry |
| pull_data | output | 32 | Data of the presented entry |
| empty | output | 1 | Queue and output stage both empty |
| full | output | 1 | Storage holds 2**ADDR_W entries |
| put_gray | output | ADDR_W+1 | Gray-coded write index |
| get_gray | output | ADDR_W+1 | Gray-coded read index |

## Verification
A push sampled at one edge gives its `push_ok` or `runout` pulse, its `cur_chan` change and its `full` and `put_gray` update right after that same edge. The bench therefore drives just after a rising edge and checks these results at the next falling edge. An accepted entry reaches the output stage one edge after it is written, so `pull_valid` rises two edges after the push. The scoreboard monitor compares entries at falling edges whenever `pull_valid` and `pull_ready` are both high, which is exactly the cycle whose next edge removes the entry. `get_gray` and `empty` are read only after the queue has drained, where their values do not depend on the ready pattern.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int SUBCH_W  = 3;
  localparam int METHOD_W = 11;
  localparam int DATA_W   = 32;

  typedef struct packed {
    logic [SUBCH_W-1:0]  subch;
    logic [METHOD_W-1:0] method;
    logic [DATA_W-1:0]   data;
  } cmd_t;
endpackage

// File: rtl/cmdq_gray_ptr.sv
module cmdq_gray_ptr #(
  parameter int AW = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  output logic [AW:0] gray,
  output logic [AW-1:0] addr
);
  logic [AW:0] gray_q;
  logic [AW:0] bin;
  logic [AW:0] bin_nxt;

  always_comb begin
    bin[AW] = gray_q[AW];
    for (int i = AW - 1; i >= 0; i--) begin
      bin[i] = bin[i+1] ^ gray_q[i];
    end
  end

  assign bin_nxt = bin + (AW+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      gray_q <= '0;
    end else if (step) begin
      gray_q <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

  assign gray = gray_q;
  assign addr = bin[AW-1:0];
endmodule

// File: rtl/cmdq_store.sv
module cmdq_store
  import cmdq_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  cmd_t          wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output cmd_t          rdata
);
  localparam int DEPTH = 1 << AW;

  cmd_t mem [DEPTH];
  cmd_t rd_q;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rd_q <= mem[raddr];
    end
  end

  assign rdata = rd_q;
endmodule

// File: rtl/cmdq_chan_gate.sv
module cmdq_chan_gate #(
  parameter int CHAN_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [CHAN_W-1:0] push_chan,
  input  logic              push_en,
  input  logic              sw_en,
  input  logic              q_empty,
  input  logic              q_full,
  output logic              accept,
  output logic [CHAN_W-1:0] cur_chan,
  output logic              push_ok,
  output logic              runout
);
  logic [CHAN_W-1:0] chan_q;
  logic              same_chan;
  logic              may_switch;

  assign same_chan  = (push_chan == chan_q);
  assign may_switch = q_empty && sw_en;
  assign accept     = push_valid && push_en && !q_full && (same_chan || may_switch);

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q  <= '0;
      push_ok <= 1'b0;
      runout  <= 1'b0;
    end else begin
      push_ok <= accept;
      runout  <= push_valid && !accept;
      if (accept && !same_chan) begin
        chan_q <= push_chan;
      end
    end
  end

  assign cur_chan = chan_q;
endmodule

// File: rtl/cmd_cache_fifo.sv
module cmd_cache_fifo
  import cmdq_pkg::*;
#(
  parameter int CHAN_W = 7,
  parameter int ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                glb_en,
  input  logic                cfg_wr,
  input  logic [2:0]          cfg_wdata,
  input  logic                push_valid,
  input  logic [CHAN_W-1:0]   push_chan,
  input  logic [SUBCH_W-1:0]  push_subch,
  input  logic [METHOD_W-1:0] push_method,
  input  logic [DATA_W-1:0]   push_data,
  output logic                push_ok,
  output logic                runout,
  output logic [CHAN_W-1:0]   cur_chan,
  output logic                pull_valid,
  input  logic                pull_ready,
  output logic [SUBCH_W-1:0]  pull_subch,
  output logic [METHOD_W-1:0] pull_method,
  output logic [DATA_W-1:0]   pull_data,
  output logic                empty,
  output logic                full,
  output logic [ADDR_W:0]     put_gray,
  output logic [ADDR_W:0]     get_gray
);
  localparam int CFG_PUSH = 0;
  localparam int CFG_PULL = 1;
  localparam int CFG_SW   = 2;

  logic push_en_q, pull_en_q, sw_en_q;
  logic accept, load, pop;
  logic out_valid_q;
  logic mem_empty, mem_full, q_empty;
  logic [ADDR_W:0]   wr_g, rd_g;
  logic [ADDR_W-1:0] wr_a, rd_a;
  cmd_t in_cmd, out_cmd;

  // control bits, cleared whenever the global enable is low
  always_ff @(posedge clk) begin
    if (rst || !glb_en) begin
      push_en_q <= 1'b0;
      pull_en_q <= 1'b0;
      sw_en_q   <= 1'b0;
    end else if (cfg_wr) begin
      push_en_q <= cfg_wdata[CFG_PUSH];
      pull_en_q <= cfg_wdata[CFG_PULL];
      sw_en_q   <= cfg_wdata[CFG_SW];
    end
  end

  assign mem_empty = (wr_g == rd_g);
  assign mem_full  = (wr_g == {~rd_g[ADDR_W:ADDR_W-1], rd_g[ADDR_W-2:0]});
  assign q_empty   = mem_empty && !out_valid_q;

  assign pop  = out_valid_q && pull_en_q && pull_ready;
  assign load = pull_en_q && !mem_empty && (!out_valid_q || pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
    end else if (load) begin
      out_valid_q <= 1'b1;
    end else if (pop) begin
      out_valid_q <= 1'b0;
    end
  end

  cmdq_chan_gate #(.CHAN_W(CHAN_W)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .push_valid (push_valid),
    .push_chan  (push_chan),
    .push_en    (push_en_q),
    .sw_en      (sw_en_q),
    .q_empty    (q_empty),
    .q_full     (mem_full),
    .accept     (accept),
    .cur_chan   (cur_chan),
    .push_ok    (push_ok),
    .runout     (runout)
  );

  cmdq_gray_ptr #(.AW(ADDR_W)) u_put (
    .clk  (clk),
    .rst  (rst),
    .step (accept),
    .gray (wr_g),
    .addr (wr_a)
  );

  cmdq_gray_ptr #(.AW(ADDR_W)) u_get (
    .clk  (clk),
    .rst  (rst),
    .step (load),
    .gray (rd_g),
    .addr (rd_a)
  );

  assign in_cmd = '{subch: push_subch, method: push_method, data: push_data};

  cmdq_store #(.AW(ADDR_W)) u_store (
    .clk   (clk),
    .we    (accept),
    .waddr (wr_a),
    .wdata (in_cmd),
    .re    (load),
    .raddr (rd_a),
    .rdata (out_cmd)
  );

  assign pull_valid  = out_valid_q && pull_en_q;
  assign pull_subch  = out_cmd.subch;
  assign pull_method = out_cmd.method;
  assign pull_data   = out_cmd.data;
  assign empty       = q_empty;
  assign full        = mem_full;
  assign put_gray    = wr_g;
  assign get_gray    = rd_g;
endmodule

// File: rtl/cmdq_checker.sv
module cmdq_checker #(
  parameter int CHAN_W = 7,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              glb_en,
  input logic              push_ok,
  input logic              runout,
  input logic [CHAN_W-1:0] cur_chan,
  input logic              pull_valid,
  input logic              pull_ready,
  input logic [31:0]       pull_data,
  input logic              empty,
  input logic              full,
  input logic [ADDR_W:0]   put_gray,
  input logic [ADDR_W:0]   get_gray
);
  // R7: a push is either queued or refused, never both
  a_r7_ok_xor_runout: assert property (@(posedge clk) disable iff (rst)
    !(push_ok && runout));

  // R8: each index moves one Gray step at a time
  a_r8_put_one_bit: assert property (@(posedge clk) disable iff (rst)
    !$stable(put_gray) |-> $countones(put_gray ^ $past(put_gray)) == 1);

  a_r8_get_one_bit: assert property (@(posedge clk) disable iff (rst)
    !$stable(get_gray) |-> $countones(get_gray ^ $past(get_gray)) == 1);

  a_r8_not_empty_and_full: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  // R2: nothing is accepted while storage is full
  a_r2_no_accept_full: assert property (@(posedge clk) disable iff (rst)
    push_ok |-> !$past(full));

  // R4: the owner channel only changes together with an accepted push
  a_r4_chan_moves_on_push: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_chan) |-> push_ok);

  // R9: presented entry is held until taken
  a_r9_hold_data: assert property (@(posedge clk) disable iff (rst)
    ($past(pull_valid && !pull_ready) && pull_valid) |-> $stable(pull_data));

  // R10: global enable low stops the puller and the pusher
  a_r10_glb_pull_off: assert property (@(posedge clk) disable iff (rst)
    $past(!glb_en) |-> !pull_valid);

  a_r10_glb_push_off: assert property (@(posedge clk) disable iff (rst)
    $past(!glb_en, 2) |-> !push_ok);
endmodule

bind cmd_cache_fifo cmdq_checker #(.CHAN_W(CHAN_W), .ADDR_W(ADDR_W)) u_cmdq_chk (
  .clk        (clk),
  .rst        (rst),
  .glb_en     (glb_en),
  .push_ok    (push_ok),
  .runout     (runout),
  .cur_chan   (cur_chan),
  .pull_valid (pull_valid),
  .pull_ready (pull_ready),
  .pull_data  (pull_data),
  .empty      (empty),
  .full       (full),
  .put_gray   (put_gray),
  .get_gray   (get_gray)
);

// File: tb/tb_cmd_cache_fifo.sv
module tb_cmd_cache_fifo;
  localparam int CW = 7;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic glb_en = 1'b0;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic push_valid = 1'b0;
  logic [CW-1:0] push_chan = '0;
  logic [2:0] push_subch = '0;
  logic [10:0] push_method = '0;
  logic [31:0] push_data = '0;
  logic push_ok, runout, pull_valid, empty, full;
  logic pull_ready = 1'b0;
  logic [CW-1:0] cur_chan;
  logic [2:0] pull_subch;
  logic [10:0] pull_method;
  logic [31:0] pull_data;
  logic [AW:0] put_gray, get_gray;

  int checks = 0;
  int errors = 0;
  int n_put = 0;
  int cyc = 0;
  int rdy_mode = 0;
  bit done = 0;
  logic [45:0] sb_q[$];

  cmd_cache_fifo #(.CHAN_W(CW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .glb_en(glb_en), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .push_valid(push_valid), .push_chan(push_chan), .push_subch(push_subch),
    .push_method(push_method), .push_data(push_data), .push_ok(push_ok),
    .runout(runout), .cur_chan(cur_chan), .pull_valid(pull_valid),
    .pull_ready(pull_ready), .pull_subch(pull_subch), .pull_method(pull_method),
    .pull_data(pull_data), .empty(empty), .full(full),
    .put_gray(put_gray), .get_gray(get_gray)
  );

  always #5 clk = ~clk;

  function automatic logic [AW:0] gray_of(input int n);
    logic [AW:0] b;
    b = AW'(0) | (n[AW:0]);
    return b ^ (b >> 1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ready pattern driven just after each rising edge
  always begin
    @(posedge clk);
    #1;
    cyc++;
    case (rdy_mode)
      0: pull_ready = 1'b1;
      1: pull_ready = (cyc % 3) != 0;
      default: pull_ready = 1'b0;
    endcase
  end

  // scoreboard monitor: compare every handshake against the expected order
  always @(negedge clk) begin
    if (!rst && pull_valid && pull_ready) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R1 unexpected entry", {18'd0, pull_subch, pull_method, pull_data}, 64'd0);
      end else begin
        logic [45:0] e;
        e = sb_q.pop_front();
        chk({pull_subch, pull_method, pull_data} == e, "R1 entry order/content",
            {18'd0, pull_subch, pull_method, pull_data}, {18'd0, e});
      end
    end
  end

  task automatic cfg(input logic [2:0] v);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic do_push(input logic [CW-1:0] ch, input logic [2:0] sb, input logic [10:0] mt,
                         input logic [31:0] dt, input bit exp_ok, input string req);
    @(posedge clk); #1;
    push_valid = 1'b1; push_chan = ch; push_subch = sb; push_method = mt; push_data = dt;
    @(posedge clk); #1;
    push_valid = 1'b0;
    @(negedge clk);
    chk(push_ok == exp_ok && runout == !exp_ok, req, {push_ok, runout}, {exp_ok, !exp_ok});
    if (exp_ok) begin
      sb_q.push_back({sb, mt, dt});
      n_put++;
    end
  endtask

  task automatic wait_empty(input string req);
    int k;
    k = 0;
    @(negedge clk);
    while (!empty && k < 1000) begin
      @(negedge clk);
      k++;
    end
    chk(empty && sb_q.size() == 0, req, {empty, 32'(sb_q.size())}, 64'h1_0000_0000);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(empty && !full && !pull_valid && !push_ok && !runout, "R12 reset flags",
        {empty, full, pull_valid, push_ok, runout}, 5'b10000);
    chk(put_gray == 0 && get_gray == 0 && cur_chan == 0, "R12 reset indices",
        {put_gray, get_gray, cur_chan}, 0);
    @(posedge clk); #1 glb_en = 1'b1;

    // R11/R1/R7: all enables, streaming on channel 0
    cfg(3'b111);
    for (int i = 0; i < 4; i++)
      do_push('0, 3'(i), 11'(16 + i), 32'hA000_0000 + i, 1'b1, "R7 same-channel push");
    wait_empty("R1 drained");
    chk(put_gray == gray_of(n_put) && get_gray == put_gray, "R8 gray after 4",
        {put_gray, get_gray}, {gray_of(n_put), gray_of(n_put)});

    // R3: pull off, queue holds entries, foreign channel refused
    cfg(3'b101);
    do_push('0, 3'd5, 11'h7FF, 32'hFFFF_FFFF, 1'b1, "R1 push all-ones");
    do_push('0, 3'd0, 11'h000, 32'h0, 1'b1, "R1 push zeros");
    idle(3);
    chk(!pull_valid, "R11 pull bit off", pull_valid, 0);
    do_push(7'd5, 3'd1, 11'd1, 32'd1, 1'b0, "R3 foreign channel nonempty");
    chk(cur_chan == 0, "R3 channel kept", cur_chan, 0);

    // R4: drain, then switch takes over an empty queue
    cfg(3'b111);
    wait_empty("R9 drain after enable");
    do_push(7'd5, 3'd2, 11'd300, 32'h1234_5678, 1'b1, "R4 switch on empty");
    chk(cur_chan == 7'd5, "R4 channel updated", cur_chan, 5);

    // R5: switching disabled
    cfg(3'b011);
    wait_empty("R5 empty before");
    do_push(7'd2, 3'd3, 11'd3, 32'd3, 1'b0, "R5 foreign refused sw off");
    chk(cur_chan == 7'd5, "R5 channel kept", cur_chan, 5);
    do_push(7'd5, 3'd4, 11'd4, 32'h55AA_55AA, 1'b1, "R5 same channel accepted");
    wait_empty("R5 drained");

    // R2/R8: fill to capacity with pull stopped
    cfg(3'b001);
    for (int i = 0; i < DEPTH; i++) begin
      do_push(7'd5, 3'(i), 11'(i * 7), 32'hC0DE_0000 + i, 1'b1, "R2 fill");
      chk(put_gray == gray_of(n_put), "R8 put gray step", put_gray, gray_of(n_put));
    end
    chk(full && !empty, "R2 full at depth", {full, empty}, 2'b10);
    do_push(7'd5, 3'd7, 11'd7, 32'd7, 1'b0, "R2 push when full");
    chk(put_gray == gray_of(n_put), "R2 index unchanged when full", put_gray, gray_of(n_put));
    rdy_mode = 1;
    cfg(3'b011);
    wait_empty("R9 drain with gaps");
    chk(get_gray == gray_of(n_put) && !full, "R8 get gray after drain", get_gray, gray_of(n_put));
    rdy_mode = 0;

    // R6: push access off
    cfg(3'b010);
    do_push(7'd5, 3'd1, 11'd9, 32'd9, 1'b0, "R6 push access off");
    idle(3);
    chk(empty && !pull_valid && put_gray == gray_of(n_put), "R6 nothing queued",
        {empty, pull_valid}, 2'b10);

    // R10: global enable low clears enables and ignores writes
    cfg(3'b111);
    @(posedge clk); #1 glb_en = 1'b0;
    cfg(3'b111);
    @(posedge clk); #1 glb_en = 1'b1;
    do_push(7'd5, 3'd6, 11'd6, 32'd6, 1'b0, "R10 push forced off");
    cfg(3'b001);
    do_push(7'd5, 3'd6, 11'd66, 32'h6666, 1'b1, "R10 push after rewrite");
    idle(4);
    chk(!pull_valid && !empty, "R10 pull stays off", {pull_valid, empty}, 2'b00);
    cfg(3'b011);
    wait_empty("R10 drained");

    // R9: ready low holds the entry
    rdy_mode = 2;
    @(posedge clk); #1;
    do_push(7'd5, 3'd2, 11'd22, 32'hBEEF_0022, 1'b1, "R9 push for hold");
    idle(5);
    chk(pull_valid && pull_data == 32'hBEEF_0022, "R9 held while not ready",
        {pull_valid, pull_data}, {1'b1, 32'hBEEF_0022});
    chk(sb_q.size() == 1, "R9 not consumed", sb_q.size(), 1);
    rdy_mode = 0;
    wait_empty("R9 taken after ready");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule